// File: doc/BRIEF.md
# Dirty Replication Side Cache

This block is a small, fully associative side store that holds a second copy of dirty data belonging to defective cache blocks. Such blocks spend their error-correcting strength on hiding manufacturing defects, so a later soft error could not be corrected in them. When a defective block turns dirty, the cache controller hands the block address and data to this store. If a soft error is found later, the requester asks for the copy. On a miss the requester must refetch the block from main memory, and that copy is valid because every entry that leaves the store is first written to memory.

Entries are created when a block turns dirty, never on a miss. A later dirty write to an address that is already held replaces the data in that entry. When every entry is in use, the entry written least recently is written to main memory through a valid/ready port. The new data takes that entry only after the memory write has been accepted. When the main cache writes a block back itself, the matching entry is dropped and no memory write is made. Clean blocks and defect-free blocks are never stored.

Top module: `dirty_repl_cache`

## Requirements
- R1: After reset no entry is valid, `mem_valid` and `rcv_done` are low, and the first recovery read misses.
- R2: A dirty write with `dirty_defect`=1 to an address that is not held, while a free entry exists, sees `dirty_ready`=1 in the same cycle. A recovery read issued in any later cycle returns that data.
- R3: A dirty write with `dirty_defect`=0 is accepted with `dirty_ready`=1 and has no effect: nothing is stored, nothing is evicted and no memory write is made.
- R4: A dirty write to an address that is already held overwrites that entry's data and takes no second entry.
- R5: A dirty write with `dirty_defect`=1 that misses while all entries are valid sees `dirty_ready`=0. In the next cycle `mem_valid` rises with the victim's address and data. In the cycle after the `mem_valid`/`mem_ready` handshake, `dirty_ready` is 1 and the new data replaces the victim.
- R6: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R7: In a cycle with `wb_valid`=1, any entry matching `wb_addr` is invalidated and no memory write is made. `dirty_ready` is 0 in that cycle.
- R8: A recovery read gives its result one cycle later: `rcv_done`=1 together with exactly one of `rcv_hit` (with `rcv_data`) or `rcv_refetch`. The result reflects the contents as they stood before any update made in the read's own cycle.
- R9: Recovery reads do not change which entry is chosen as the victim.
- R10: The victim is the valid entry whose most recent accepted dirty write, whether it allocated or updated the entry, is the oldest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dirty_valid | input | 1 | A block has turned dirty; held until accepted |
| dirty_ready | output | 1 | The dirty write is accepted in this cycle |
| dirty_defect | input | 1 | The block contains defective cells and needs a copy |
| dirty_addr | input | ADDR_W | Block address of the dirty write |
| dirty_data | input | DATA_W | Data to replicate |
| wb_valid | input | 1 | Main cache writes this block back itself |
| wb_addr | input | ADDR_W | Address of the written-back block |
| rcv_valid | input | 1 | Recovery read request after a soft error |
| rcv_addr | input | ADDR_W | Address to recover |
| rcv_done | output | 1 | Recovery result is valid |
| rcv_hit | output | 1 | A copy was found |
| rcv_refetch | output | 1 | No copy is held; refetch from main memory |
| rcv_data | output | DATA_W | Replicated data on a hit, else zero |
| mem_valid | output | 1 | Victim write to main memory is pending |
| mem_ready | input | 1 | Main memory accepts the write |
| mem_addr | output | ADDR_W | Victim block address |
| mem_data | output | DATA_W | Victim block data |

## Verification
`dirty_ready` is combinational, so it is compared in the same cycle as the request it answers. A store or update shows up for recovery reads issued in the next cycle. Recovery results come one clock after the request, and the victim write appears on `mem_valid` one clock after the stalled request is first presented. A write-back invalidation affects a recovery read only from the following cycle. The bench drives inputs just after each rising edge and compares every output at the falling edge against a behavioural model. That model keeps a write stamp per entry and advances its state at the rising edge, so every comparison falls on the cycle in which the result is due.

// File: rtl/drc_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the dirty replication cache.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package drc_pkg;

    // Recency update requested for one entry in a cycle.
    typedef enum logic [1:0] {
        LRU_IDLE  = 2'd0,
        LRU_TOUCH = 2'd1,   // entry written (allocated, updated or replaced)
        LRU_DROP  = 2'd2    // entry invalidated
    } lru_op_e;

    // Memory write-out state.
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_EVICT = 1'b1
    } evict_st_e;

endpackage

// File: rtl/drc_first_set.sv
`timescale 1ns/1ps
// Module: drc_first_set
// Returns the index of the lowest set bit of a vector and whether any bit
// is set. Assumes N >= 2; on an all-zero vector the index is zero.
module drc_first_set #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);

    // Scan from the top so the lowest set bit is the final assignment.
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/drc_tag_cam.sv
`timescale 1ns/1ps
// Module: drc_tag_cam
// Compares a lookup key with every stored tag at once and returns one match
// bit per entry. Only valid entries can match. Assumes that the owner never
// stores one address in two entries.
module drc_tag_cam #(
    parameter int N      = 64,
    parameter int ADDR_W = 32
) (
    input  logic [N-1:0]             valid_i,
    input  logic [N-1:0][ADDR_W-1:0] tags_i,
    input  logic [ADDR_W-1:0]        key_i,
    output logic [N-1:0]             match_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            // One comparator per entry.
            assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
        end
    endgenerate

endmodule

// File: rtl/drc_lru_rank.sv
`timescale 1ns/1ps
// Module: drc_lru_rank
// Keeps a recency rank for each entry: 0 is the most recent write, and the
// valid entries always hold the ranks 0..count-1 without gaps. A touch moves
// an entry to rank 0. A newly allocated entry counts as older than every
// valid one, so all valid entries age by one. A drop closes the gap above
// the dropped rank. When every entry is valid, the victim is the single
// entry at rank N-1.
// Assumes: at most one operation per cycle; valid_i is the state before the
// edge; N is a power of two, N >= 2.
module drc_lru_rank
    import drc_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_i,
    input  lru_op_e          op_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [N-1:0]     victim_o
);

    logic [IDX_W-1:0] rank_q [N];
    logic [IDX_W:0]   pivot;

    // Entries below the pivot age on a touch; a fresh entry ages all of them.
    always_comb begin
        pivot = valid_i[idx_i] ? {1'b0, rank_q[idx_i]} : (IDX_W + 1)'(N);
    end

    // Rank update for the requested operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank_q[i] <= '0;
        end else begin
            case (op_i)
                LRU_TOUCH: begin
                    for (int i = 0; i < N; i++) begin
                        if (IDX_W'(i) == idx_i)
                            rank_q[i] <= '0;
                        else if (valid_i[i] && ({1'b0, rank_q[i]} < pivot))
                            rank_q[i] <= rank_q[i] + 1'b1;
                    end
                end
                LRU_DROP: begin
                    for (int i = 0; i < N; i++) begin
                        if (valid_i[i] && (rank_q[i] > rank_q[idx_i]))
                            rank_q[i] <= rank_q[i] - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_vic
            // The oldest valid entry sits at the top rank when the store is full.
            assign victim_o[g] = valid_i[g] && (rank_q[g] == IDX_W'(N - 1));
        end
    endgenerate

    // R10: a full store always offers exactly one victim.
    p_one_victim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_i) |-> ($countones(victim_o) == 1));

    // R10: a touched entry becomes the most recent and so cannot be the next victim.
    p_touch_not_victim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == LRU_TOUCH) |=> !victim_o[$past(idx_i)]);

endmodule

// File: rtl/dirty_repl_cache.sv
`timescale 1ns/1ps
// Module: dirty_repl_cache (top)
// A fully associative store for second copies of dirty data from defective
// cache blocks. Dirty writes allocate entries or update them in place. A
// write that misses a full store first writes the least recently written
// entry to memory and then replaces it. Main-cache write-backs drop entries
// without a memory write. Recovery reads answer one cycle later.
// Assumes: a requester holds dirty_* steady until dirty_ready; memory holds
// mem_ready meaningful only while mem_valid is high.
module dirty_repl_cache
    import drc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 64,
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dirty_valid,
    output logic              dirty_ready,
    input  logic              dirty_defect,
    input  logic [ADDR_W-1:0] dirty_addr,
    input  logic [DATA_W-1:0] dirty_data,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic              rcv_valid,
    input  logic [ADDR_W-1:0] rcv_addr,
    output logic              rcv_done,
    output logic              rcv_hit,
    output logic              rcv_refetch,
    output logic [DATA_W-1:0] rcv_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);

    localparam int IDX_W = $clog2(ENTRIES);

    // Entry storage
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][DATA_W-1:0] data_q;

    evict_st_e st_q;
    logic      vic_done_q;   // victim already written to memory

    // Lookups
    logic [ENTRIES-1:0] d_match, w_match, r_match, vic_vec;
    logic [IDX_W-1:0]   d_idx, w_idx, r_idx, free_idx, vic_idx, wr_idx;
    logic               d_any, w_any, r_any, free_any, vic_any;

    logic    idle, dirty_take, start_evict;
    lru_op_e lru_op;
    logic [IDX_W-1:0] lru_idx;

    drc_tag_cam #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_cam_dirty (
        .valid_i(valid_q), .tags_i(tag_q), .key_i(dirty_addr), .match_o(d_match));
    drc_tag_cam #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_cam_wb (
        .valid_i(valid_q), .tags_i(tag_q), .key_i(wb_addr), .match_o(w_match));
    drc_tag_cam #(.N(ENTRIES), .ADDR_W(ADDR_W)) u_cam_rcv (
        .valid_i(valid_q), .tags_i(tag_q), .key_i(rcv_addr), .match_o(r_match));

    drc_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_dirty (
        .vec_i(d_match), .idx_o(d_idx), .any_o(d_any));
    drc_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_wb (
        .vec_i(w_match), .idx_o(w_idx), .any_o(w_any));
    drc_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_rcv (
        .vec_i(r_match), .idx_o(r_idx), .any_o(r_any));
    drc_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_free (
        .vec_i(~valid_q), .idx_o(free_idx), .any_o(free_any));
    drc_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_enc_vic (
        .vec_i(vic_vec), .idx_o(vic_idx), .any_o(vic_any));

    drc_lru_rank #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_q),
        .op_i(lru_op), .idx_i(lru_idx), .victim_o(vic_vec));

    // Accept decision, target entry and the recency operation for this cycle.
    always_comb begin
        idle        = (st_q == ST_IDLE);
        dirty_ready = idle && !wb_valid &&
                      (!dirty_defect || d_any || free_any || vic_done_q);
        dirty_take  = dirty_valid && dirty_ready && dirty_defect;
        start_evict = idle && dirty_valid && dirty_defect && !wb_valid &&
                      !d_any && !free_any && !vic_done_q && vic_any;
        wr_idx      = d_any ? d_idx : (free_any ? free_idx : vic_idx);
        if (wb_valid && w_any) begin
            lru_op  = LRU_DROP;
            lru_idx = w_idx;
        end else if (dirty_take) begin
            lru_op  = LRU_TOUCH;
            lru_idx = wr_idx;
        end else begin
            lru_op  = LRU_IDLE;
            lru_idx = '0;
        end
    end

    // Valid bits: drop on write-back, set on an accepted dirty write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wb_valid && w_any) begin
            valid_q[w_idx] <= 1'b0;
        end else if (dirty_take) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and data payload of the written entry.
    always_ff @(posedge clk) begin
        if (dirty_take) begin
            tag_q[wr_idx]  <= dirty_addr;
            data_q[wr_idx] <= dirty_data;
        end
    end

    // Victim write-out sequence toward main memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            vic_done_q <= 1'b0;
            mem_addr   <= '0;
            mem_data   <= '0;
        end else begin
            if (start_evict) begin
                st_q     <= ST_EVICT;
                mem_addr <= tag_q[vic_idx];
                mem_data <= data_q[vic_idx];
            end else if (st_q == ST_EVICT && mem_ready) begin
                st_q       <= ST_IDLE;
                vic_done_q <= 1'b1;
            end
            if (dirty_valid && dirty_ready) vic_done_q <= 1'b0;
        end
    end

    assign mem_valid = (st_q == ST_EVICT);

    // Recovery read result, registered one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcv_done    <= 1'b0;
            rcv_hit     <= 1'b0;
            rcv_refetch <= 1'b0;
            rcv_data    <= '0;
        end else begin
            rcv_done    <= rcv_valid;
            rcv_hit     <= rcv_valid && r_any;
            rcv_refetch <= rcv_valid && !r_any;
            rcv_data    <= (rcv_valid && r_any) ? data_q[r_idx] : '0;
        end
    end

    // R1: reset leaves the store empty.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0) && !mem_valid && !rcv_done);

    // R3: a write without defects changes no entry.
    p_clean_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_valid && !dirty_defect && !wb_valid && !mem_valid)
            |-> dirty_ready ##1 $stable(valid_q));

    // R4: no address is ever held twice.
    p_single_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(d_match) <= 1);

    // R5: no dirty write is accepted while the victim write is pending.
    p_evict_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !dirty_ready);

    // R6: a pending memory write holds until accepted.
    p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready)
            |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R7: a write-back cycle blocks the dirty port.
    p_wb_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !dirty_ready);

    // R8: every recovery request is answered next cycle with one outcome.
    p_rcv_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_valid |=> rcv_done && (rcv_hit != rcv_refetch));

endmodule

// File: tb/dirty_repl_cache_tb_top.sv
`timescale 1ns/1ps
module dirty_repl_cache_tb_top;

    localparam int AW = 32;
    localparam int DW = 64;
    localparam int N  = 64;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic          rst_n;
    logic          dirty_valid, dirty_ready, dirty_defect;
    logic [AW-1:0] dirty_addr;
    logic [DW-1:0] dirty_data;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic          rcv_valid;
    logic [AW-1:0] rcv_addr;
    logic          rcv_done, rcv_hit, rcv_refetch;
    logic [DW-1:0] rcv_data;
    logic          mem_valid, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;

    dirty_repl_cache #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dirty_valid(dirty_valid), .dirty_ready(dirty_ready),
        .dirty_defect(dirty_defect), .dirty_addr(dirty_addr), .dirty_data(dirty_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr),
        .rcv_valid(rcv_valid), .rcv_addr(rcv_addr), .rcv_done(rcv_done),
        .rcv_hit(rcv_hit), .rcv_refetch(rcv_refetch), .rcv_data(rcv_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data));

    int    checks = 0;
    int    fails  = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    int    mr_pct = 50;

    // Behavioural model: entries with a write stamp; oldest stamp is the victim.
    bit            mv [N];
    logic [AW-1:0] mt [N];
    logic [DW-1:0] md [N];
    longint        ms [N];
    longint        stamp = 0;
    bit            m_evict, m_vdone;
    logic [AW-1:0] m_ma;
    logic [DW-1:0] m_md;
    bit            e_done, e_hit, e_ref;
    logic [DW-1:0] e_data;

    function automatic int find(logic [AW-1:0] a);
        for (int i = 0; i < N; i++) if (mv[i] && mt[i] == a) return i;
        return -1;
    endfunction

    function automatic int free_slot();
        for (int i = 0; i < N; i++) if (!mv[i]) return i;
        return -1;
    endfunction

    function automatic int oldest();
        int k = -1;
        for (int i = 0; i < N; i++)
            if (mv[i] && (k < 0 || ms[i] < ms[k])) k = i;
        return k;
    endfunction

    function automatic int count();
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(mv[i]);
        return c;
    endfunction

    function automatic bit exp_ready();
        return !m_evict && !wb_valid &&
               (!dirty_defect || find(dirty_addr) >= 0 || free_slot() >= 0 || m_vdone);
    endfunction

    task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) mv[i] = 1'b0;
        m_evict = 0; m_vdone = 0; e_done = 0; e_hit = 0; e_ref = 0; e_data = '0;
    endtask

    // One clock: compare at the falling edge, advance the model at the rising edge.
    task automatic tick();
        bit rdy, was_evict;
        int k;
        @(negedge clk);
        rdy = exp_ready();
        if (rst_n) begin
            chk("dirty_ready", DW'(dirty_ready), DW'(rdy));
            chk("mem_valid", DW'(mem_valid), DW'(m_evict));
            if (m_evict) begin
                chk("mem_addr", DW'(mem_addr), DW'(m_ma));
                chk("mem_data", mem_data, m_md);
            end
            chk("rcv_done", DW'(rcv_done), DW'(e_done));
            chk("rcv_hit", DW'(rcv_hit), DW'(e_hit));
            chk("rcv_refetch", DW'(rcv_refetch), DW'(e_ref));
            if (e_hit) chk("rcv_data", rcv_data, e_data);
        end
        @(posedge clk);
        if (!rst_n) begin
            model_reset();
        end else begin
            k = find(rcv_addr);
            e_done = rcv_valid;
            e_hit  = rcv_valid && k >= 0;
            e_ref  = rcv_valid && k < 0;
            e_data = (k >= 0) ? md[k] : '0;
            was_evict = m_evict;
            if (m_evict && mem_ready) begin
                m_evict = 0;
                m_vdone = 1;
            end
            if (wb_valid) begin
                k = find(wb_addr);
                if (k >= 0) mv[k] = 1'b0;
            end else if (!was_evict && dirty_valid) begin
                if (rdy) begin
                    m_vdone = 0;
                    if (dirty_defect) begin
                        k = find(dirty_addr);
                        if (k < 0) k = free_slot();
                        if (k < 0) k = oldest();
                        mv[k] = 1'b1; mt[k] = dirty_addr; md[k] = dirty_data;
                        ms[k] = stamp; stamp++;
                    end
                end else if (dirty_defect) begin
                    k = oldest();
                    m_evict = 1; m_ma = mt[k]; m_md = md[k];
                end
            end
        end
        #1;
    endtask

    task automatic dwrite(logic [AW-1:0] a, logic [DW-1:0] d, bit def);
        bit took;
        dirty_valid = 1; dirty_addr = a; dirty_data = d; dirty_defect = def;
        do begin
            mem_ready = ($urandom_range(99) < mr_pct);
            took = exp_ready();
            tick();
        end while (!took);
        dirty_valid = 0; mem_ready = 0;
    endtask

    task automatic rd(logic [AW-1:0] a);
        rcv_valid = 1; rcv_addr = a;
        tick();
        rcv_valid = 0;
        tick();
    endtask

    task automatic wback(logic [AW-1:0] a);
        wb_valid = 1; wb_addr = a;
        tick();
        wb_valid = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete (expected completion)");
        summary();
    end

    initial begin
        rst_n = 0; dirty_valid = 0; dirty_defect = 0; dirty_addr = '0; dirty_data = '0;
        wb_valid = 0; wb_addr = '0; rcv_valid = 0; rcv_addr = '0; mem_ready = 0;
        model_reset();
        repeat (3) tick();
        rst_n = 1;

        // R1: outputs idle after reset, first recovery read misses.
        cur_req = "R1";
        tick();
        rd(32'h5);

        // R3: writes from defect-free blocks are not stored.
        cur_req = "R3";
        dwrite(32'h100, 64'hAAAA_0000_0000_0001, 1'b0);
        rd(32'h100);

        // R2: allocate and read back.
        cur_req = "R2";
        for (int i = 0; i < 10; i++) dwrite(32'h200 + i, {32'hD0D0, 32'(i)}, 1'b1);
        for (int i = 0; i < 10; i++) rd(32'h200 + i);

        // R4: rewrite in place.
        cur_req = "R4";
        for (int i = 0; i < 5; i++) dwrite(32'h200 + i, {32'hBEEF, 32'(i)}, 1'b1);
        for (int i = 0; i < 5; i++) rd(32'h200 + i);

        // R10: fill the store, then evict in write order.
        cur_req = "R10";
        for (int i = 0; count() < N; i++) dwrite(32'h300 + i, {32'h3333, 32'(i)}, 1'b1);
        for (int i = 0; i < 6; i++) dwrite(32'h400 + i, {32'h4444, 32'(i)}, 1'b1);
        rd(32'h205);

        // R5: stall and handshake with memory readily accepting.
        cur_req = "R5";
        mr_pct = 100;
        for (int i = 0; i < 3; i++) dwrite(32'h500 + i, {32'h5555, 32'(i)}, 1'b1);

        // R6: slow memory keeps the pending write on the port.
        cur_req = "R6";
        mr_pct = 15;
        for (int i = 0; i < 5; i++) dwrite(32'h600 + i, {32'h6666, 32'(i)}, 1'b1);

        // R9: recovery reads of the oldest entries leave the eviction order alone.
        cur_req = "R9";
        mr_pct = 50;
        for (int i = 0; i < 8; i++) rd(32'h300 + i);
        for (int i = 0; i < 4; i++) dwrite(32'h700 + i, {32'h7777, 32'(i)}, 1'b1);

        // R7: write-backs drop entries with no memory write; freed slots reused.
        cur_req = "R7";
        for (int i = 0; i < 4; i++) wback(32'h700 + i);
        wback(32'hFFFF);
        for (int i = 0; i < 4; i++) rd(32'h700 + i);
        dirty_valid = 1; dirty_defect = 1; dirty_addr = 32'h800; dirty_data = 64'h88;
        wb_valid = 1; wb_addr = 32'h401;
        tick();
        wb_valid = 0;
        for (int i = 0; i < 4; i++) dwrite(32'h800 + i, {32'h8888, 32'(i)}, 1'b1);

        // R8: mixed random traffic on all ports.
        cur_req = "R8";
        for (int c = 0; c < 4000; c++) begin
            bit took;
            if (!dirty_valid && $urandom_range(2) == 0) begin
                dirty_valid  = 1;
                dirty_addr   = 32'h1000 + $urandom_range(95);
                dirty_data   = {$urandom, $urandom};
                dirty_defect = ($urandom_range(4) != 0);
            end
            wb_valid  = ($urandom_range(7) == 0);
            wb_addr   = 32'h1000 + $urandom_range(95);
            rcv_valid = $urandom_range(1);
            rcv_addr  = 32'h1000 + $urandom_range(95);
            mem_ready = $urandom_range(1);
            took = dirty_valid && exp_ready();
            tick();
            if (took) dirty_valid = 0;
        end
        dirty_valid = 0; wb_valid = 0; rcv_valid = 0;
        repeat (3) tick();
        summary();
    end

endmodule